// File: doc/BRIEF.md
# Interrupt Pin Request and End-of-Interrupt Engine

This block turns raw interrupt pin levels into delivery messages. Each pin has a set of routing fields supplied from outside: a vector, a destination, a logical/physical destination flag, a delivery-mode code, a trigger-mode flag, an active-low flag and a mask bit. The block keeps three per-pin state bits. The request bit is the registered effective level. The in-service bit blocks a level-triggered pin until its handler acknowledges it. The pending bit holds a request that is waiting for the message port.

Messages leave one at a time on a valid/ready port. A message stays on the port unchanged until the consumer takes it with ready high. While the port is busy, new requests wait in the pending bits. When the port frees, the lowest-numbered pending pin goes next. An end-of-interrupt (EOI) strobe carries an 8-bit vector and a level flag. A level EOI releases every entry that uses that vector, and any released pin that is still asserted is requested again in the same cycle. A one-cycle `coalesced` pulse marks a new assertion that could not be queued.

Top module: `pin_req_engine`

## Requirements
- R1: A pin's effective level is `pin_level` XOR `cfg_active_low`. The request bit takes the effective level on each clock, so it clears when the effective level is low.
- R2: An edge-triggered pin (`cfg_level_trig`=0) raises a request only in the cycle its request bit goes from 0 to 1. The message is valid right after that clock edge. Holding the pin high gives no further message.
- R3: A level-triggered pin raises a request while its effective level is high and its in-service bit is clear. Issuing its message sets the in-service bit. A new 0-to-1 assertion while the in-service bit or the pending bit is set produces a one-cycle `coalesced` pulse for that pin and no message.
- R4: A pin whose `cfg_mask` bit is 1 produces no message, sets no in-service bit and raises no `coalesced` pulse. A level pin held high is requested in the cycle after its mask clears.
- R5: An EOI with `eoi_level`=1 clears the in-service bit of every entry whose vector equals `eoi_vector`. Each such level-triggered entry that is unmasked and whose request bit is still 1 is requested again in that same cycle.
- R6: An EOI with `eoi_level`=0 has no effect. An EOI whose vector no entry uses has no effect. The check for the second case uses a 256-bit map of the vectors present in the table.
- R7: Messages from pin 0 always carry `msg_dest_logical`=0 and `msg_dest`=BOOT_ID, whatever that pin's table fields say.
- R8: When several requests are waiting, one message is issued per accepted transfer, in ascending pin order. The rest stay pending.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and every message field stays unchanged.
- R10: Reset clears the request, in-service and pending bits, `msg_valid` and `coalesced`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | N_PINS | Raw pin levels |
| cfg_vector | input | 8*N_PINS | Vector of each entry, pin i at bits [8i+7:8i] |
| cfg_dest | input | DEST_W*N_PINS | Destination of each entry |
| cfg_dest_logical | input | N_PINS | 1 = logical destination mode |
| cfg_dmode | input | 3*N_PINS | Delivery-mode code of each entry |
| cfg_level_trig | input | N_PINS | 1 = level-triggered, 0 = edge-triggered |
| cfg_active_low | input | N_PINS | 1 = pin is active low |
| cfg_mask | input | N_PINS | 1 = entry masked |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-type EOI |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dest_logical | output | 1 | Message destination mode |
| msg_dmode | output | 3 | Message delivery mode |
| msg_level_trig | output | 1 | Message trigger mode |
| msg_pin | output | PIN_W | Source pin of the message |
| coalesced | output | N_PINS | One-cycle per-pin coalesced pulse |

## Verification
The mask checks assume the routing fields change only between clock edges and are otherwise held steady. They compare each new message and each coalesced pulse with a registered copy of the mask. The bench keeps the table fixed through the vector walk. It changes a single mask bit once, in a directed step, half a cycle before the edge that should act on it. All stimulus, including `msg_ready`, changes on the falling edge, so the stability check sees clean back-pressure cycles.

// File: rtl/pinreq_pkg.sv
package pinreq_pkg;
  localparam int VEC_W   = 8;
  localparam int DMODE_W = 3;
  localparam int DEST_W  = 8;

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DEST_W-1:0]  dest;
    logic               logical;
    logic [DMODE_W-1:0] dmode;
    logic               level_trig;
  } msg_t;
endpackage

// File: rtl/pinreq_vecmap.sv
module pinreq_vecmap #(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8
) (
  input  logic [N_PINS*VEC_W-1:0] cfg_vector,
  output logic [(1<<VEC_W)-1:0]   present
);
  always_comb begin
    present = '0;
    for (int i = 0; i < N_PINS; i++)
      present[cfg_vector[i*VEC_W +: VEC_W]] = 1'b1;
  end
endmodule

// File: rtl/pinreq_front.sv
module pinreq_front #(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8
) (
  input  logic [N_PINS-1:0]       pin_level,
  input  logic [N_PINS-1:0]       cfg_active_low,
  input  logic [N_PINS-1:0]       cfg_level_trig,
  input  logic [N_PINS-1:0]       cfg_mask,
  input  logic [N_PINS*VEC_W-1:0] cfg_vector,
  input  logic [N_PINS-1:0]       irr_q,
  input  logic [N_PINS-1:0]       busy_q,
  input  logic [N_PINS-1:0]       pend_q,
  input  logic                    eoi_fire,
  input  logic [VEC_W-1:0]        eoi_vector,
  output logic [N_PINS-1:0]       eff,
  output logic [N_PINS-1:0]       new_req,
  output logic [N_PINS-1:0]       coal_d,
  output logic [N_PINS-1:0]       eoi_match
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic rise, lvl_go, edge_go, redo;
    assign eff[i]       = pin_level[i] ^ cfg_active_low[i];
    assign rise         = eff[i] & ~irr_q[i];
    assign eoi_match[i] = eoi_fire && (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector);
    assign lvl_go       = cfg_level_trig[i] & eff[i] & ~busy_q[i] & ~pend_q[i];
    assign edge_go      = ~cfg_level_trig[i] & rise & ~pend_q[i];
    assign redo         = cfg_level_trig[i] & eoi_match[i] & irr_q[i] & ~pend_q[i];
    assign new_req[i]   = (lvl_go | edge_go | redo) & ~cfg_mask[i];
    assign coal_d[i]    = rise & ~cfg_mask[i] &
                          (cfg_level_trig[i] ? (busy_q[i] | pend_q[i]) : pend_q[i]);
  end
endmodule

// File: rtl/pinreq_pick.sv
module pinreq_pick #(
  parameter int N_PINS = 8,
  localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic [N_PINS-1:0] req,
  output logic [N_PINS-1:0] grant,
  output logic [PIN_W-1:0]  idx,
  output logic              any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = PIN_W'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/pin_req_engine.sv
module pin_req_engine
  import pinreq_pkg::*;
#(
  parameter int              N_PINS  = 8,
  parameter logic [DEST_W-1:0] BOOT_ID = 8'h01,
  localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PINS-1:0]         pin_level,
  input  logic [N_PINS*VEC_W-1:0]   cfg_vector,
  input  logic [N_PINS*DEST_W-1:0]  cfg_dest,
  input  logic [N_PINS-1:0]         cfg_dest_logical,
  input  logic [N_PINS*DMODE_W-1:0] cfg_dmode,
  input  logic [N_PINS-1:0]         cfg_level_trig,
  input  logic [N_PINS-1:0]         cfg_active_low,
  input  logic [N_PINS-1:0]         cfg_mask,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic                      eoi_level,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [VEC_W-1:0]          msg_vector,
  output logic [DEST_W-1:0]         msg_dest,
  output logic                      msg_dest_logical,
  output logic [DMODE_W-1:0]        msg_dmode,
  output logic                      msg_level_trig,
  output logic [PIN_W-1:0]          msg_pin,
  output logic [N_PINS-1:0]         coalesced
);
  localparam int MAP_N = 1 << VEC_W;

  logic [N_PINS-1:0] irr_q, busy_q, pend_q, coal_q;
  logic [N_PINS-1:0] eff, new_req, coal_d, eoi_match;
  logic [N_PINS-1:0] cand, grant, pend_d, busy_d;
  logic [MAP_N-1:0]  present;
  logic [PIN_W-1:0]  sel;
  logic              any, load, eoi_fire, out_v_q;
  msg_t              msg_q, msg_d;
  logic [PIN_W-1:0]  pin_q;

  pinreq_vecmap #(.N_PINS(N_PINS), .VEC_W(VEC_W)) u_map (
    .cfg_vector(cfg_vector), .present(present)
  );

  assign eoi_fire = eoi_valid & eoi_level & present[eoi_vector];

  pinreq_front #(.N_PINS(N_PINS), .VEC_W(VEC_W)) u_front (
    .pin_level(pin_level), .cfg_active_low(cfg_active_low),
    .cfg_level_trig(cfg_level_trig), .cfg_mask(cfg_mask),
    .cfg_vector(cfg_vector), .irr_q(irr_q), .busy_q(busy_q),
    .pend_q(pend_q), .eoi_fire(eoi_fire), .eoi_vector(eoi_vector),
    .eff(eff), .new_req(new_req), .coal_d(coal_d), .eoi_match(eoi_match)
  );

  assign cand = pend_q | new_req;

  pinreq_pick #(.N_PINS(N_PINS)) u_pick (
    .req(cand), .grant(grant), .idx(sel), .any(any)
  );

  assign load = any & (~out_v_q | msg_ready);

  always_comb begin
    pend_d = load ? (cand & ~grant) : cand;
    busy_d = busy_q & ~eoi_match;
    if (load && cfg_level_trig[sel]) busy_d = busy_d | grant;
    msg_d.vector     = cfg_vector[sel*VEC_W +: VEC_W];
    msg_d.dmode      = cfg_dmode[sel*DMODE_W +: DMODE_W];
    msg_d.level_trig = cfg_level_trig[sel];
    if (sel == '0) begin
      msg_d.dest    = BOOT_ID;
      msg_d.logical = 1'b0;
    end else begin
      msg_d.dest    = cfg_dest[sel*DEST_W +: DEST_W];
      msg_d.logical = cfg_dest_logical[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q   <= '0;
      busy_q  <= '0;
      pend_q  <= '0;
      coal_q  <= '0;
      out_v_q <= 1'b0;
      msg_q   <= '0;
      pin_q   <= '0;
    end else begin
      irr_q  <= eff;
      busy_q <= busy_d;
      pend_q <= pend_d;
      coal_q <= coal_d;
      if (load) begin
        out_v_q <= 1'b1;
        msg_q   <= msg_d;
        pin_q   <= sel;
      end else if (msg_ready) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign msg_valid        = out_v_q;
  assign msg_vector       = msg_q.vector;
  assign msg_dest         = msg_q.dest;
  assign msg_dest_logical = msg_q.logical;
  assign msg_dmode        = msg_q.dmode;
  assign msg_level_trig   = msg_q.level_trig;
  assign msg_pin          = pin_q;
  assign coalesced        = coal_q;
endmodule

// File: rtl/pin_req_engine_chk.sv
module pin_req_engine_chk
  import pinreq_pkg::*;
#(
  parameter int                N_PINS  = 8,
  parameter logic [DEST_W-1:0] BOOT_ID = 8'h01,
  localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_PINS-1:0]   cfg_mask,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [VEC_W-1:0]    msg_vector,
  input logic [DEST_W-1:0]   msg_dest,
  input logic                msg_dest_logical,
  input logic [DMODE_W-1:0]  msg_dmode,
  input logic                msg_level_trig,
  input logic [PIN_W-1:0]    msg_pin,
  input logic [N_PINS-1:0]   coalesced
);
  logic [N_PINS-1:0] mask_q;
  always_ff @(posedge clk) mask_q <= cfg_mask;

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_dest_logical) && $stable(msg_dmode)
      && $stable(msg_level_trig) && $stable(msg_pin));

  // R7
  boot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_pin == '0 |-> !msg_dest_logical && msg_dest == BOOT_ID);

  // R4
  masked_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !mask_q[msg_pin]);

  // R4
  masked_no_coal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coalesced & mask_q) == '0);
endmodule

bind pin_req_engine pin_req_engine_chk #(.N_PINS(N_PINS), .BOOT_ID(BOOT_ID)) u_chk (.*);

// File: tb/pin_req_engine_bench.sv
module pin_req_engine_bench;
  localparam int N = 8;
  localparam logic [7:0] BOOT = 8'h01;

  typedef struct packed {
    logic [7:0] pins;
    logic       ev;
    logic [7:0] evec;
    logic       elvl;
    logic       rdy;
    logic       xv;
    logic [2:0] xpin;
    logic [7:0] xcoal;
  } step_t;

  localparam int NSTEP = 19;
  localparam step_t TBL [NSTEP] = '{
    '{8'h04,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h05,1'b0,8'h00,1'b0,1'b1,1'b1,3'd0,8'h00},
    '{8'h05,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h07,1'b0,8'h00,1'b0,1'b1,1'b1,3'd1,8'h00},
    '{8'h07,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h05,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h07,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h02},
    '{8'h07,1'b1,8'h31,1'b1,1'b1,1'b1,3'd1,8'h00},
    '{8'h03,1'b0,8'h00,1'b0,1'b0,1'b1,3'd1,8'h00},
    '{8'h03,1'b0,8'h00,1'b0,1'b1,1'b1,3'd2,8'h00},
    '{8'h03,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h03,1'b1,8'h99,1'b1,1'b1,1'b0,3'd0,8'h00},
    '{8'h03,1'b1,8'h31,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h03,1'b1,8'h31,1'b1,1'b1,1'b1,3'd1,8'h00},
    '{8'h03,1'b0,8'h00,1'b0,1'b1,1'b1,3'd2,8'h00},
    '{8'h03,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h02,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00},
    '{8'h0B,1'b0,8'h00,1'b0,1'b1,1'b1,3'd0,8'h00},
    '{8'h0B,1'b0,8'h00,1'b0,1'b1,1'b0,3'd0,8'h00}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]   pin_level;
  logic [N*8-1:0] cfg_vector = {8'h50,8'h50,8'h50,8'h50,8'h40,8'h31,8'h31,8'h20};
  logic [N*8-1:0] cfg_dest   = {8'h78,8'h78,8'h78,8'h78,8'h56,8'h34,8'h12,8'h05};
  logic [N-1:0]   cfg_dest_logical = 8'h03;
  logic [N*3-1:0] cfg_dmode  = 24'h000008;
  logic [N-1:0]   cfg_level_trig   = 8'hF6;
  logic [N-1:0]   cfg_active_low   = 8'h04;
  logic [N-1:0]   cfg_mask         = 8'hF8;
  logic           eoi_valid, eoi_level, msg_ready;
  logic [7:0]     eoi_vector;
  logic           msg_valid, msg_dest_logical, msg_level_trig;
  logic [7:0]     msg_vector, msg_dest;
  logic [2:0]     msg_dmode, msg_pin;
  logic [N-1:0]   coalesced;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pin_req_engine #(.N_PINS(N), .BOOT_ID(BOOT)) u_pin_req_engine (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_vector(cfg_vector),
    .cfg_dest(cfg_dest), .cfg_dest_logical(cfg_dest_logical), .cfg_dmode(cfg_dmode),
    .cfg_level_trig(cfg_level_trig), .cfg_active_low(cfg_active_low),
    .cfg_mask(cfg_mask), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
    .msg_dmode(msg_dmode), .msg_level_trig(msg_level_trig), .msg_pin(msg_pin),
    .coalesced(coalesced)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] p, input logic ev, input logic [7:0] vec,
                       input logic lv, input logic rdy);
    @(negedge clk);
    pin_level  = p;
    eoi_valid  = ev;
    eoi_vector = vec;
    eoi_level  = lv;
    msg_ready  = rdy;
    @(posedge clk);
    #2;
  endtask

  task automatic check_msg(input logic xv, input logic [2:0] xp, input string req);
    chk(msg_valid === xv, req, 32'(msg_valid), 32'(xv));
    if (xv) begin
      chk(msg_pin === xp, req, 32'(msg_pin), 32'(xp));
      chk(msg_vector === cfg_vector[xp*8 +: 8], {req, " vector"},
          32'(msg_vector), 32'(cfg_vector[xp*8 +: 8]));
      chk(msg_dest === ((xp == 0) ? BOOT : cfg_dest[xp*8 +: 8]), {req, " R7 dest"},
          32'(msg_dest), 32'((xp == 0) ? BOOT : cfg_dest[xp*8 +: 8]));
      chk(msg_dest_logical === ((xp == 0) ? 1'b0 : cfg_dest_logical[xp]), {req, " R7 mode"},
          32'(msg_dest_logical), 32'((xp == 0) ? 1'b0 : cfg_dest_logical[xp]));
      chk(msg_level_trig === cfg_level_trig[xp] && msg_dmode === cfg_dmode[xp*3 +: 3],
          {req, " trig/dmode"}, {28'd0, msg_dmode, msg_level_trig},
          {28'd0, cfg_dmode[xp*3 +: 3], cfg_level_trig[xp]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_level = 8'h04; eoi_valid = 0; eoi_vector = 0; eoi_level = 0; msg_ready = 1;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk(msg_valid === 1'b0, "R10 valid", 32'(msg_valid), 0);
    chk(coalesced === '0, "R10 coalesced", 32'(coalesced), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R5 R6 R8 R9: vector walk
    for (int s = 0; s < NSTEP; s++) begin
      drive(TBL[s].pins, TBL[s].ev, TBL[s].evec, TBL[s].elvl, TBL[s].rdy);
      check_msg(TBL[s].xv, TBL[s].xpin, $sformatf("R2/R3/R5/R8/R9 step %0d msg", s));
      chk(coalesced === TBL[s].xcoal, $sformatf("R3/R6 step %0d coalesced", s),
          32'(coalesced), 32'(TBL[s].xcoal));
    end

    // R4: masked level pin 4 asserted: nothing happens
    drive(8'h1B, 0, 8'h00, 0, 1);
    check_msg(1'b0, 3'd0, "R4 masked msg");
    chk(coalesced === '0, "R4 masked coalesced", 32'(coalesced), 0);
    // R4: unmask while held high -> request next edge
    @(negedge clk);
    cfg_mask = 8'hE8;
    @(posedge clk);
    #2;
    check_msg(1'b1, 3'd4, "R4 unmask msg");
    drive(8'h1B, 0, 8'h00, 0, 1);
    check_msg(1'b0, 3'd0, "R4 after accept");
    // R3: re-assert pin 4 while in service
    drive(8'h0B, 0, 8'h00, 0, 1);
    drive(8'h1B, 0, 8'h00, 0, 1);
    chk(coalesced === 8'h10, "R3 pin4 coalesced", 32'(coalesced), 32'h10);
    check_msg(1'b0, 3'd0, "R3 pin4 no msg");
    // R5: EOI on shared vector of pins 4..7 redelivers pin 4 only
    drive(8'h1B, 1, 8'h50, 1, 1);
    check_msg(1'b1, 3'd4, "R5 redeliver pin4");
    drive(8'h1B, 0, 8'h00, 0, 1);
    check_msg(1'b0, 3'd0, "R5 single redelivery");

    // R10: mid-run reset with a message waiting
    drive(8'h1A, 0, 8'h00, 0, 0);
    drive(8'h1B, 0, 8'h00, 0, 0);
    check_msg(1'b1, 3'd0, "R2 pin0 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    chk(msg_valid === 1'b0, "R10 mid-run valid", 32'(msg_valid), 0);
    chk(coalesced === '0, "R10 mid-run coalesced", 32'(coalesced), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule